// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

The block is a transmitter and receiver pair for start/stop serial framing, steered by a single 8-bit mode byte. The mode byte chooses whether a parity bit is added, which parity sense is used, how long the stop period is, and how many clock cycles make up one bit period. A separate 2-bit input sets the character length to 5, 6, 7 or 8 data bits. A host loads characters through a one-deep transmit holding register and collects received characters together with parity-error and framing-error flags.

The transmitter can stretch its stop period to one and a half bit periods. The receiver checks exactly one stop bit whatever the mode byte asks for, and then looks for the next start bit at once. For characters shorter than eight bits, the received parity bit is handed back inside the data byte. A stop-field value of zero selects a synchronous mode, which this block does not implement. In that mode both directions simply stay idle.

Top module: `sio_async_port`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, `rx_valid` is 0, `rx_data` is 0 and both error flags are 0. The mode byte resets to 0x00, which selects the idle synchronous setting, so no character is sent or received until a mode byte is written.
- R2: A pulse on `mode_wr` stores `mode_data`. In the stored byte, bit 0 enables parity and bit 1 selects even parity when 1. Bits 3:2 select the stop period (00 synchronous/idle, 01 one, 10 one and a half, 11 two). Bits 7:6 select the bit period M in clock cycles (00 = 1, 01 = 16, 10 = 32, 11 = 64). Bits 5:4 have no effect. `char_len` values 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits.
- R3: A transmitted frame is one low start bit, then the data bits least significant first, then the parity bit when enabled, then the stop period at level 1. Each bit lasts M cycles, and `txd` is 1 when the line is idle.
- R4: With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number. This rule applies both when generating and when checking.
- R5: The stop period lasts M cycles for code 01 and 2M cycles for code 11. For code 10 it lasts 3M/2 cycles when M > 1, and 2 cycles when M = 1.
- R6: A write on `tx_wr` is accepted only while `tx_empty` is 1, and accepting it clears `tx_empty`. `tx_empty` returns to 1 in the cycle the character moves into the shifter. A character waiting in the holding register starts right after the previous stop period, with no idle cycle in between. A write made while `tx_empty` is 0 is dropped.
- R7: When M > 1, a falling edge on `rxd` is checked again half a bit period later. If the line is high by then, the edge is discarded and no character results.
- R8: The receiver samples each bit at its centre and checks a single stop bit whatever the stop-period code. After that it immediately watches for a new start bit.
- R9: `rx_data` carries the received data bits in its low bits. When parity is enabled and fewer than 8 data bits are used, the received parity bit sits in the bit position just above the data bits. All higher bits are 0.
- R10: `rx_parity_err` is 1 for a character only when parity is enabled and the received parity bit breaks the selected parity sense.
- R11: `rx_frame_err` is 1 for a character whose checked stop bit was sampled low.
- R12: `rx_valid` rises one cycle after a character completes. A pulse on `rx_rd` clears it one cycle later. If a character completes in the same cycle as `rx_rd`, the new character wins and `rx_valid` stays 1.
- R13: While the stop-period code is 00, `txd` stays 1, transmit writes are dropped (`tx_empty` stays 1), and nothing on `rxd` produces a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_wr | input | 1 | Store `mode_data` into the mode byte |
| mode_data | input | 8 | New mode byte |
| char_len | input | 2 | Data bits per character, 5 + value |
| tx_wr | input | 1 | Load `tx_data` into the transmit holding register |
| tx_data | input | 8 | Character to transmit |
| tx_empty | output | 1 | Transmit holding register can take a character |
| rx_rd | input | 1 | Host has taken the received character |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | An unread character is present |
| rx_parity_err | output | 1 | Parity error on the last character |
| rx_frame_err | output | 1 | Framing error on the last character |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
A character can finish arriving in the very cycle the host acknowledges the previous one, so the set and clear of `rx_valid` meet at the same edge. The bench provokes this by holding `rx_rd` high for a whole incoming frame. Under the new-character-wins rule, `rx_valid` must then be seen high for exactly one sampled cycle, carrying the new data. A second overlap is the transmit holding register refilling while the shifter is still in its stop period. This is judged by measuring the stop period exactly and seeing the next start bit follow with no gap.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int NB_W   = $clog2(DATA_W) + 1;

  typedef struct packed {
    logic [1:0] rate;
    logic [1:0] spare;
    logic [1:0] stop;
    logic       even;
    logic       par_en;
  } mode_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  localparam logic [1:0] STOP_SYNC     = 2'b00;
  localparam logic [1:0] STOP_ONE      = 2'b01;
  localparam logic [1:0] STOP_ONE_HALF = 2'b10;

  function automatic logic [CNT_W-1:0] bit_cycles(input logic [1:0] rate);
    case (rate)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(16);
      2'b10:   return CNT_W'(32);
      default: return CNT_W'(64);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] stop_cycles(input logic [1:0] stop,
                                                   input logic [1:0] rate);
    logic [CNT_W-1:0] m;
    m = bit_cycles(rate);
    case (stop)
      STOP_ONE:      return m;
      STOP_ONE_HALF: return (m == CNT_W'(1)) ? CNT_W'(2) : m + (m >> 1);
      default:       return m << 1;
    endcase
  endfunction

  function automatic logic [NB_W-1:0] char_bits(input logic [1:0] sel);
    return NB_W'(5) + NB_W'(sel);
  endfunction

  function automatic logic [DATA_W-1:0] char_mask(input logic [NB_W-1:0] n);
    logic [DATA_W-1:0] mk;
    for (int i = 0; i < DATA_W; i++) mk[i] = (i < int'(n));
    return mk;
  endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_t             mode,
  input  logic [1:0]        len_sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic              txd,
  output logic              empty,
  output logic              load
);
  localparam int IDX_W = $clog2(DATA_W);

  phase_t            ph;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cyc;
  logic [IDX_W-1:0]  idx;
  logic              par_q;

  logic              sync_md;
  logic [CNT_W-1:0]  bit_len;
  logic [CNT_W-1:0]  stop_len;
  logic [NB_W-1:0]   nbits;
  logic              bit_end;
  logic              stop_end;
  logic              last_bit;
  logic              do_load;
  logic [DATA_W-1:0] masked;
  logic              par_gen;

  always_comb begin
    sync_md  = (mode.stop == STOP_SYNC);
    bit_len  = bit_cycles(mode.rate);
    stop_len = stop_cycles(mode.stop, mode.rate);
    nbits    = char_bits(len_sel);
    bit_end  = (cyc == bit_len - CNT_W'(1));
    stop_end = (cyc == stop_len - CNT_W'(1));
    last_bit = ({1'b0, idx} == nbits - NB_W'(1));
    do_load  = !sync_md && hold_full &&
               ((ph == PH_IDLE) || ((ph == PH_STOP) && stop_end));
    masked   = hold_q & char_mask(nbits);
    par_gen  = mode.even ? ^masked : ~^masked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      txd       <= 1'b1;
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh        <= '0;
      cyc       <= '0;
      idx       <= '0;
      par_q     <= 1'b0;
      load      <= 1'b0;
    end else begin
      load <= 1'b0;
      if (sync_md) begin
        ph        <= PH_IDLE;
        txd       <= 1'b1;
        hold_full <= 1'b0;
        cyc       <= '0;
      end else if (do_load) begin
        sh        <= masked;
        par_q     <= par_gen;
        hold_full <= 1'b0;
        load      <= 1'b1;
        ph        <= PH_START;
        txd       <= 1'b0;
        cyc       <= '0;
      end else begin
        if (wr && !hold_full) begin
          hold_q    <= din;
          hold_full <= 1'b1;
        end
        case (ph)
          PH_IDLE: txd <= 1'b1;
          PH_START: begin
            if (bit_end) begin
              cyc <= '0;
              idx <= '0;
              ph  <= PH_DATA;
              txd <= sh[0];
            end else cyc <= cyc + CNT_W'(1);
          end
          PH_DATA: begin
            if (bit_end) begin
              cyc <= '0;
              if (last_bit) begin
                if (mode.par_en) begin
                  ph  <= PH_PAR;
                  txd <= par_q;
                end else begin
                  ph  <= PH_STOP;
                  txd <= 1'b1;
                end
              end else begin
                idx <= idx + IDX_W'(1);
                sh  <= sh >> 1;
                txd <= sh[1];
              end
            end else cyc <= cyc + CNT_W'(1);
          end
          PH_PAR: begin
            if (bit_end) begin
              cyc <= '0;
              ph  <= PH_STOP;
              txd <= 1'b1;
            end else cyc <= cyc + CNT_W'(1);
          end
          PH_STOP: begin
            if (stop_end) begin
              cyc <= '0;
              ph  <= PH_IDLE;
            end else cyc <= cyc + CNT_W'(1);
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  assign empty = ~hold_full;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_t             mode,
  input  logic [1:0]        len_sel,
  input  logic              rxd_s,
  output logic              done,
  output logic [DATA_W-1:0] dout,
  output logic              perr,
  output logic              ferr
);
  localparam int IDX_W = $clog2(DATA_W);

  phase_t            ph;
  logic [CNT_W-1:0]  cyc;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sh;
  logic              par_q;

  logic              sync_md;
  logic [CNT_W-1:0]  bit_len;
  logic [NB_W-1:0]   nbits;
  logic              bit_end;
  logic              half_end;
  logic              last_bit;
  logic [DATA_W-1:0] dmask;
  logic [DATA_W-1:0] assembled;
  logic              par_bad;

  always_comb begin
    sync_md   = (mode.stop == STOP_SYNC);
    bit_len   = bit_cycles(mode.rate);
    nbits     = char_bits(len_sel);
    bit_end   = (cyc == bit_len - CNT_W'(1));
    half_end  = (cyc == (bit_len >> 1) - CNT_W'(1));
    last_bit  = ({1'b0, idx} == nbits - NB_W'(1));
    dmask     = sh & char_mask(nbits);
    assembled = dmask;
    if (mode.par_en && (nbits < NB_W'(DATA_W)))
      assembled = dmask | ({{(DATA_W-1){1'b0}}, par_q} << nbits);
    par_bad   = mode.par_en && (par_q != (mode.even ? ^dmask : ~^dmask));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cyc   <= '0;
      idx   <= '0;
      sh    <= '0;
      par_q <= 1'b0;
      done  <= 1'b0;
      dout  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sync_md) begin
        ph  <= PH_IDLE;
        cyc <= '0;
      end else begin
        case (ph)
          PH_IDLE: begin
            if (!rxd_s) begin
              cyc <= '0;
              idx <= '0;
              sh  <= '0;
              ph  <= (bit_len == CNT_W'(1)) ? PH_DATA : PH_START;
            end
          end
          PH_START: begin
            if (half_end) begin
              cyc <= '0;
              ph  <= rxd_s ? PH_IDLE : PH_DATA;
            end else cyc <= cyc + CNT_W'(1);
          end
          PH_DATA: begin
            if (bit_end) begin
              cyc     <= '0;
              sh[idx] <= rxd_s;
              if (last_bit) ph <= mode.par_en ? PH_PAR : PH_STOP;
              else          idx <= idx + IDX_W'(1);
            end else cyc <= cyc + CNT_W'(1);
          end
          PH_PAR: begin
            if (bit_end) begin
              cyc   <= '0;
              par_q <= rxd_s;
              ph    <= PH_STOP;
            end else cyc <= cyc + CNT_W'(1);
          end
          PH_STOP: begin
            if (bit_end) begin
              cyc  <= '0;
              done <= 1'b1;
              dout <= assembled;
              perr <= par_bad;
              ferr <= !rxd_s;
              ph   <= PH_IDLE;
            end else cyc <= cyc + CNT_W'(1);
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_async_port.sv
module sio_async_port
  import sio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [7:0]        mode_data,
  input  logic [1:0]        char_len,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_parity_err,
  output logic              rx_frame_err,
  input  logic              rxd,
  output logic              txd
);
  mode_t mode_q;
  logic  rxd_s;
  logic  tx_load;
  logic  rx_done;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= mode_t'(mode_data);
  end

  sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (rxd_s)
  );

  sio_tx u_tx (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .len_sel (char_len),
    .wr      (tx_wr),
    .din     (tx_data),
    .txd     (txd),
    .empty   (tx_empty),
    .load    (tx_load)
  );

  sio_rx u_rx (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .len_sel (char_len),
    .rxd_s   (rxd_s),
    .done    (rx_done),
    .dout    (rx_data),
    .perr    (rx_parity_err),
    .ferr    (rx_frame_err)
  );

  always_ff @(posedge clk) begin
    if (rst)          rx_valid <= 1'b0;
    else if (rx_done) rx_valid <= 1'b1;
    else if (rx_rd)   rx_valid <= 1'b0;
  end
endmodule

// File: rtl/sio_async_port_chk.sv
module sio_async_port_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] mode_bits,
  input logic       txd,
  input logic       tx_empty,
  input logic       tx_load,
  input logic       rx_rd,
  input logic       rx_done,
  input logic       rx_valid,
  input logic       rx_parity_err
);
  a_r13_sync_line_high: assert property (@(posedge clk) disable iff (rst)
    (mode_bits[3:2] == 2'b00) |=> txd);

  a_r3_load_drives_start: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> !txd);

  a_r6_load_frees_holding: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> tx_empty);

  a_r12_done_sets_valid: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_valid);

  a_r12_read_clears_valid: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !rx_done) |=> !rx_valid);

  a_r10_no_perr_without_parity: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !mode_bits[0]) |-> !rx_parity_err);
endmodule

bind sio_async_port sio_async_port_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_bits     (mode_q),
  .txd           (txd),
  .tx_empty      (tx_empty),
  .tx_load       (tx_load),
  .rx_rd         (rx_rd),
  .rx_done       (rx_done),
  .rx_valid      (rx_valid),
  .rx_parity_err (rx_parity_err)
);

// File: tb/sio_async_port_tb_top.sv
module sio_async_port_tb_top;
  localparam int STOP_LIMIT = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0;
  logic [7:0] mode_data = '0;
  logic [1:0] char_len = '0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_empty;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_parity_err;
  logic       rx_frame_err;
  logic       rxd = 1'b1;
  logic       txd;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sio_async_port dut_i (
    .clk           (clk),
    .rst           (rst),
    .mode_wr       (mode_wr),
    .mode_data     (mode_data),
    .char_len      (char_len),
    .tx_wr         (tx_wr),
    .tx_data       (tx_data),
    .tx_empty      (tx_empty),
    .rx_rd         (rx_rd),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err),
    .rx_frame_err  (rx_frame_err),
    .rxd           (rxd),
    .txd           (txd)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mult(input logic [1:0] r);
    case (r)
      2'b00:   return 1;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 64;
    endcase
  endfunction

  function automatic logic [7:0] lenmask(input int n);
    return 8'hFF >> (8 - n);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input int n, input bit even);
    logic [7:0] m;
    m = d & lenmask(n);
    return even ? ^m : ~^m;
  endfunction

  function automatic logic [15:0] exp_frame(input logic [7:0] d, input int n,
                                            input bit pe, input bit even);
    logic [15:0] f;
    f = '0;
    for (int i = 0; i < n; i++) f[1+i] = d[i];
    if (pe) f[1+n] = par_of(d, n, even);
    return f;
  endfunction

  task automatic wr_mode(input logic [7:0] m, input logic [1:0] len);
    @(negedge clk);
    mode_data = m;
    char_len  = len;
    mode_wr   = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] d);
    tx_data = d;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic rx_read();
    @(negedge clk);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic capture(input int m, input int ns,
                         output logic [15:0] bits, output int stop_cnt);
    bits = '0;
    while (txd !== 1'b0) @(negedge clk);
    for (int i = 1; i < ns; i++) begin
      repeat (m) @(negedge clk);
      bits[i] = txd;
    end
    repeat (m) @(negedge clk);
    stop_cnt = 0;
    while (txd === 1'b1 && stop_cnt < STOP_LIMIT) begin
      stop_cnt++;
      @(negedge clk);
    end
  endtask

  task automatic rx_frame(input int m, input int n, input logic [7:0] d,
                          input bit pe, input logic pb,
                          input int stop_cyc, input logic stop_val);
    rxd = 1'b0;
    repeat (m) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = d[i];
      repeat (m) @(negedge clk);
    end
    if (pe) begin
      rxd = pb;
      repeat (m) @(negedge clk);
    end
    rxd = stop_val;
    repeat (stop_cyc) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "txd", 32'(txd), 32'd1);
    chk("R1", "tx_empty", 32'(tx_empty), 32'd1);
    chk("R1", "rx_valid", 32'(rx_valid), 32'd0);
    chk("R1", "rx_data", 32'(rx_data), 32'd0);
    chk("R1", "err flags", {30'd0, rx_parity_err, rx_frame_err}, 32'd0);
  endtask

  task automatic t_sync_idle(input string req);
    int lows;
    @(negedge clk);
    tx_write(8'h5A);
    @(negedge clk);
    chk(req, "tx_empty after dropped write", 32'(tx_empty), 32'd1);
    lows = 0;
    fork
      rx_frame(16, 8, 8'h00, 1'b0, 1'b0, 16, 1'b1);
      repeat (200) begin
        @(negedge clk);
        if (txd !== 1'b1) lows++;
      end
    join
    chk(req, "txd low cycles in idle mode", 32'(lows), 32'd0);
    chk(req, "no character in idle mode", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_tx_pair(input logic [7:0] mode, input logic [1:0] len,
                           input logic [7:0] a, input logic [7:0] b,
                           input int exp_stop);
    int m, n, ns, sa, sb;
    bit pe, ev;
    logic [15:0] fa, fb, fm;
    wr_mode(mode, len);
    m  = mult(mode[7:6]);
    n  = 5 + int'(len);
    pe = mode[0];
    ev = mode[1];
    ns = 1 + n + (pe ? 1 : 0);
    fm = 16'hFFFF >> (16 - ns);
    @(negedge clk);
    fork
      begin
        capture(m, ns, fa, sa);
        capture(m, ns, fb, sb);
      end
      begin
        tx_write(a);
        while (tx_empty !== 1'b1) @(negedge clk);
        tx_write(b);
        tx_write(8'hFF);
      end
    join
    chk("R3", "first frame bits (R2 R4)", 32'(fa & fm), 32'(exp_frame(a, n, pe, ev)));
    chk("R5", "stop length before next start (R6 no gap)", 32'(sa), 32'(exp_stop));
    chk("R3", "second frame bits (R4)", 32'(fb & fm), 32'(exp_frame(b, n, pe, ev)));
    chk("R6", "write while full dropped, line stays idle", 32'(sb), 32'(STOP_LIMIT));
    chk("R6", "tx_empty after drain", 32'(tx_empty), 32'd1);
  endtask

  task automatic t_rx(input string req, input logic [7:0] mode, input logic [1:0] len,
                      input logic [7:0] d, input bit flip_par);
    int m, n;
    bit pe, ev;
    logic pb;
    logic [7:0] exp;
    wr_mode(mode, len);
    m  = mult(mode[7:6]);
    n  = 5 + int'(len);
    pe = mode[0];
    ev = mode[1];
    pb = par_of(d, n, ev) ^ flip_par;
    exp = d & lenmask(n);
    if (pe && n < 8) exp = exp | (8'(pb) << n);
    @(negedge clk);
    rx_frame(m, n, d, pe, pb, m, 1'b1);
    repeat (m + 6) @(negedge clk);
    chk(req, "rx_valid after frame (R8)", 32'(rx_valid), 32'd1);
    chk("R9", "rx_data", 32'(rx_data), 32'(exp));
    chk("R10", "parity flag", 32'(rx_parity_err), 32'(pe && flip_par));
    chk("R11", "framing flag clear", 32'(rx_frame_err), 32'd0);
    rx_read();
    @(negedge clk);
    chk("R12", "rx_valid cleared by read", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_frame_err();
    wr_mode(8'h44, 2'b11);
    @(negedge clk);
    rx_frame(16, 8, 8'hC3, 1'b0, 1'b0, 12, 1'b0);
    repeat (8) @(negedge clk);
    chk("R11", "framing flag on low stop", 32'(rx_frame_err), 32'd1);
    chk("R11", "data with framing error", 32'(rx_data), 32'hC3);
    rx_read();
    repeat (60) @(negedge clk);
    chk("R8", "no spurious character after bad stop", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_glitch();
    wr_mode(8'h44, 2'b11);
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (250) @(negedge clk);
    chk("R7", "short low pulse discarded", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_collision();
    int seen;
    logic [7:0] got;
    bit stop_mon;
    wr_mode(8'h44, 2'b11);
    seen = 0;
    got = '0;
    stop_mon = 0;
    @(negedge clk);
    rx_rd = 1'b1;
    fork
      begin
        rx_frame(16, 8, 8'h69, 1'b0, 1'b0, 16, 1'b1);
        repeat (30) @(negedge clk);
        stop_mon = 1;
      end
      begin
        while (!stop_mon) begin
          @(negedge clk);
          if (rx_valid === 1'b1) begin
            seen++;
            got = rx_data;
          end
        end
      end
    join
    rx_rd = 1'b0;
    chk("R12", "valid cycles with read held high", 32'(seen), 32'd1);
    chk("R12", "data seen during overlap", 32'(got), 32'h69);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sync_idle("R1");
    t_tx_pair(8'h44, 2'b11, 8'hA5, 8'h3C, 16);
    t_tx_pair(8'h7B, 2'b10, 8'h5A, 8'h17, 24);
    t_tx_pair(8'h8D, 2'b01, 8'h2E, 8'h31, 64);
    t_tx_pair(8'h08, 2'b00, 8'h15, 8'h0A, 2);
    t_tx_pair(8'hC4, 2'b11, 8'h81, 8'h7E, 64);
    t_rx("R8", 8'h44, 2'b11, 8'h3C, 1'b0);
    t_rx("R9", 8'h4B, 2'b10, 8'h5A, 1'b0);
    t_rx("R10", 8'h4B, 2'b10, 8'h5A, 1'b1);
    t_rx("R9", 8'h05, 2'b00, 8'h05, 1'b0);
    t_rx("R8", 8'h8D, 2'b01, 8'h2B, 1'b0);
    t_rx("R10", 8'h47, 2'b11, 8'hB4, 1'b1);
    t_frame_err();
    t_glitch();
    t_collision();
    wr_mode(8'h40, 2'b11);
    t_sync_idle("R13");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule